// File: doc/BRIEF.md
# Counter Skipping Multiples of Seven

This block is a free-running sequence source. After a synchronous reset it presents the integer 1, then moves to the next integer on every clock. It never presents a value that divides evenly by seven, so the order runs 1, 2, 3, 4, 5, 6, 8, 9, and so on. Each value stays on the bus for exactly one cycle, and a valid flag marks the cycles that carry a sequence value.

The block needs no divider. A three-bit register holds the current value modulo seven and moves in step with the value. When that residue reaches six, the next plain increment would land on a multiple of seven, so the value steps by two and the residue returns to one. The output width is a parameter. When the next value would not fit in that width, the sequence restarts at 1, so zero never shows up after a wrap.

Top module: `skip7_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, the cycle that follows shows `seq_vld` low and `seq_val` equal to 1.
- R2: The first cycle after reset is released shows `seq_vld` high and `seq_val` equal to 1.
- R3: Once `seq_vld` is high it stays high until the next reset, and `seq_val` takes a new value on every clock, so no value is held for more than one cycle.
- R4: While `seq_vld` is high, `seq_val` is never zero and never an integer multiple of 7.
- R5: While no wrap occurs, each value is the smallest integer above the previous value that is not a multiple of 7. The step is therefore +1, or +2 when the value after the plain increment is a multiple of 7.
- R6: When that successor would be larger than 2^WIDTH-1, the next value is 1, and the sequence then continues from 1 as it does after reset.
- R7: Counted from the first valid cycle, the first thirteen values are 1, 2, 3, 4, 5, 6, 8, 9, 10, 11, 12, 13, 15.
- R8: A reset asserted in the middle of a run restarts the sequence: `seq_vld` drops, and after release the sequence begins again at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| seq_val | output | WIDTH | Current sequence value |
| seq_vld | output | 1 | High on every cycle that carries a sequence value |

## Verification
The bench runs a 6-bit instance and a default 16-bit instance side by side. A behavioural model checks every cycle of both. The bench follows each instance through its residue wrapping from six back to one, where a design that forgets the +2 step would put 7, 14 or 63 on the bus. It also follows each instance past the top of its width, where a design that only truncates the sum would put 0 or a small multiple of seven on the bus instead of 1. Two resets check the first valid cycle, the first after power-up and one in the middle of a run. A design that advanced on its first valid cycle would show 2 there, and one that left the residue stale would skip the wrong values after the restart.

// File: rtl/skip7_pkg.sv
package skip7_pkg;

  // Divisor whose multiples are excluded from the sequence.
  localparam int unsigned MODULUS = 7;
  localparam int unsigned RES_W   = $clog2(MODULUS);

  typedef logic [RES_W-1:0] res_t;

  localparam res_t RES_ONE  = res_t'(1);
  localparam res_t RES_LAST = res_t'(MODULUS - 1);

  // True when the value after a plain increment would be a multiple.
  function automatic logic res_at_last(input res_t r);
    return r == RES_LAST;
  endfunction

  // Residue of the next emitted value, ignoring width wrap.
  function automatic res_t res_next(input res_t r);
    return res_at_last(r) ? RES_ONE : r + res_t'(1);
  endfunction

  // Amount added to the value for one advance.
  function automatic logic [1:0] step_for(input logic last);
    return last ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/skip7_launch.sv
module skip7_launch (
  input  logic clk,
  input  logic rst,
  output logic running
);

  // Low in reset; high from the first cycle that shows the start value.
  always_ff @(posedge clk) begin
    if (rst) running <= 1'b0;
    else     running <= 1'b1;
  end

endmodule

// File: rtl/skip7_residue.sv
module skip7_residue
  import skip7_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic wrap,
  output res_t res,
  output logic at_last
);

  always_ff @(posedge clk) begin
    if (rst)       res <= RES_ONE;
    else if (adv)  res <= wrap ? RES_ONE : res_next(res);
  end

  assign at_last = res_at_last(res);

endmodule

// File: rtl/skip7_stepper.sv
module skip7_stepper
  import skip7_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             at_last,
  output logic [WIDTH-1:0] val,
  output logic             wrap
);

  localparam int unsigned SUM_W = WIDTH + 1;
  localparam logic [WIDTH-1:0] START = WIDTH'(1);

  logic [SUM_W-1:0] step_ext;
  logic [SUM_W-1:0] sum;

  assign step_ext = SUM_W'(step_for(at_last));
  assign sum      = {1'b0, val} + step_ext;
  // Carry out of the value width means the successor does not fit.
  assign wrap     = sum[WIDTH];

  always_ff @(posedge clk) begin
    if (rst)       val <= START;
    else if (adv)  val <= wrap ? START : sum[WIDTH-1:0];
  end

endmodule

// File: rtl/skip7_seq.sv
module skip7_seq
  import skip7_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  output logic [WIDTH-1:0] seq_val,
  output logic             seq_vld
);

  logic running;
  logic adv;
  logic wrap_evt;
  logic last_evt;
  res_t res_cur;

  skip7_launch u_launch (
    .clk     (clk),
    .rst     (rst),
    .running (running)
  );

  // The start value is shown once before the first advance.
  assign adv = running;

  skip7_residue u_residue (
    .clk     (clk),
    .rst     (rst),
    .adv     (adv),
    .wrap    (wrap_evt),
    .res     (res_cur),
    .at_last (last_evt)
  );

  skip7_stepper #(.WIDTH(WIDTH)) u_stepper (
    .clk     (clk),
    .rst     (rst),
    .adv     (adv),
    .at_last (last_evt),
    .val     (seq_val),
    .wrap    (wrap_evt)
  );

  assign seq_vld = running;

endmodule

// File: rtl/skip7_seq_chk.sv
module skip7_seq_chk
  import skip7_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] seq_val,
  input logic             seq_vld,
  input res_t             res,
  input logic             wrap_evt
);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!seq_vld && seq_val == WIDTH'(1))); // R1

  AST_FIRST_ONE: assert property (@(posedge clk) disable iff (rst)
    $rose(seq_vld) |-> seq_val == WIDTH'(1)); // R2

  AST_STAYS_VALID: assert property (@(posedge clk) disable iff (rst)
    seq_vld |=> seq_vld); // R3

  AST_NEW_EACH_CYCLE: assert property (@(posedge clk) disable iff (rst)
    seq_vld |=> seq_val != $past(seq_val)); // R3

  AST_NO_MULTIPLE: assert property (@(posedge clk) disable iff (rst)
    seq_vld |-> (seq_val != '0 && (int'(seq_val) % int'(MODULUS)) != 0)); // R4

  AST_RESIDUE_TRACKS: assert property (@(posedge clk) disable iff (rst)
    seq_vld |-> int'(res) == (int'(seq_val) % int'(MODULUS))); // R4

  AST_SMALL_STEP: assert property (@(posedge clk) disable iff (rst)
    (seq_vld && !wrap_evt) |=>
      ((int'(seq_val) - int'($past(seq_val))) == 1 ||
       (int'(seq_val) - int'($past(seq_val))) == 2)); // R5

  AST_WRAP_TO_ONE: assert property (@(posedge clk) disable iff (rst)
    (seq_vld && wrap_evt) |=> seq_val == WIDTH'(1)); // R6

endmodule

bind skip7_seq skip7_seq_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .seq_val  (seq_val),
  .seq_vld  (seq_vld),
  .res      (res_cur),
  .wrap_evt (wrap_evt)
);

// File: tb/skip7_seq_test.sv
module skip7_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int NARROW_W   = 6;
  localparam int WIDE_W     = 16;
  localparam int NARROW_MAX = (1 << NARROW_W) - 1;
  localparam int WIDE_MAX   = (1 << WIDE_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NARROW_W-1:0] val_n;
  logic                vld_n;
  logic [WIDE_W-1:0]   val_w;
  logic                vld_w;

  skip7_seq #(.WIDTH(NARROW_W)) uut (
    .clk(clk), .rst(rst), .seq_val(val_n), .seq_vld(vld_n)
  );

  skip7_seq uut_wide (
    .clk(clk), .rst(rst), .seq_val(val_w), .seq_vld(vld_w)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  int reset_count = 1;
  bit done = 1'b0;
  bit rst_at_edge = 1'b1;

  int prev [2];
  bit fresh [2];
  int order_idx [2];
  int wraps [2];
  int ref_order [13] = '{1, 2, 3, 4, 5, 6, 8, 9, 10, 11, 12, 13, 15};

  // Model: next integer that is not a multiple of 7, back to 1 past the top.
  function automatic int succ(input int p, input int maxv);
    int n = p + 1;
    while (n % 7 == 0) n++;
    if (n > maxv) n = 1;
    return n;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic lane(input int ln, input int v, input bit vd, input int maxv);
    int e;
    if (rst_at_edge) begin
      check(!vd, "R1", $sformatf("lane%0d valid in reset", ln), int'(vd), 0);
      check(v == 1, "R1", $sformatf("lane%0d value in reset", ln), v, 1);
      fresh[ln] = 1'b1;
    end else if (fresh[ln]) begin
      check(vd && v == 1, (reset_count > 1) ? "R8" : "R2",
            $sformatf("lane%0d first value", ln), v, 1);
      fresh[ln] = 1'b0;
      prev[ln] = v;
      order_idx[ln] = 1;
    end else begin
      e = succ(prev[ln], maxv);
      check(vd, "R3", $sformatf("lane%0d valid held", ln), int'(vd), 1);
      check(v != prev[ln], "R3", $sformatf("lane%0d value changed", ln), v, e);
      check(v == e, (e == 1) ? "R6" : "R5", $sformatf("lane%0d successor", ln), v, e);
      check(v != 0 && v % 7 != 0, "R4", $sformatf("lane%0d not multiple", ln), v, e);
      if (order_idx[ln] < 13) begin
        check(v == ref_order[order_idx[ln]], "R7",
              $sformatf("lane%0d order index %0d", ln, order_idx[ln]),
              v, ref_order[order_idx[ln]]);
        order_idx[ln]++;
      end
      if (e == 1 && v == 1) wraps[ln]++;
      prev[ln] = v;
    end
  endtask

  always @(posedge clk) rst_at_edge <= rst;

  always @(negedge clk) begin
    if (!done) begin
      lane(0, int'(val_n), vld_n, NARROW_MAX);
      lane(1, int'(val_w), vld_w, WIDE_MAX);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (300) @(negedge clk);
    rst = 1'b1;
    reset_count++;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (56400) @(negedge clk);
    done = 1'b1;
    check(wraps[0] > 0, "R6", "narrow lane wrapped", wraps[0], 1);
    check(wraps[1] > 0, "R6", "wide lane wrapped", wraps[1], 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    done = 1'b1;
    n_tests++;
    n_fail++;
    $display("FAIL R3 watchdog: actual %0d expected %0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule